// File: doc/BRIEF.md
# Cell Balance Supervisor Controller

This block is the digital core of a shunt-type balancer for a series stack of four to six storage cells. Each cell arrives as an unsigned millivolt code. A three-bit level select and an offset select set three thresholds for every cell: a balance-start level and two over-voltage levels above it. Each cell compares its code against the three levels. Each comparison goes through an agreement filter that samples once per interval. The filter changes its state only after four samples in a row call for the new state. The sample interval comes from a prescaler on the system clock.

A filtered balance detection turns on that cell's shunt switch enable. Each over-voltage level raises a pull-low request if any active cell has detected that level. The self-check output asks for a low level only when every active cell is shunting and its drain feedback reads low. Cell positions above the configured count always pass the check, and they never shunt or raise a flag. When enable is low the block is in standby: all enables are off, every request is released and the filter state is cleared.

All three flag outputs are open-drain enables: a 1 means the pin is pulled low, and a 0 means it floats.

Top module: `cell_balance_ctrl`

## Requirements
- R1: The balance threshold is 2400 + 100·vsel mV, with vsel taken as an unsigned 3-bit value from 0 to 7. A cell whose code is at or above the threshold shunts (shunt_en[i]=1). A cell one code below it does not.
- R2: Over-voltage level 1 is the balance threshold plus 150 mV when ofs_sel=0, and plus 250 mV when ofs_sel=1. ov1_pull=1 if some active cell is at or above it.
- R3: Over-voltage level 2 is the balance threshold plus 300 mV when ofs_sel=0, and plus 500 mV when ofs_sel=1. ov2_pull=1 if some active cell is at or above it.
- R4: The sample interval is tick_div+1 clock cycles. Suppose the inputs are steady and enable rises just before clock edge 1. Then a detection appears after edge 4·(tick_div+1) and is absent after the edge before it. A detector changes only at an edge where a sample is taken.
- R5: A detector returns to the inactive state after four consecutive non-detecting samples, which is between three and four intervals after the input changes. A condition that lasts fewer than four samples leaves the output unchanged.
- R6: While enable=0, shunt_en, ov1_pull, ov2_pull and ok_pull are all 0, and the filter state is cleared. After enable rises again, a detection needs four fresh samples.
- R7: ov1_pull and ov2_pull are each the OR, over the active cells, of that level's filtered detection. A value of 1 means the pin is driven low.
- R8: Active cell i passes the self-check when shunt_en[i]=1 and drain_fb[i]=0. ok_pull=1 (driven low) only when every cell position passes.
- R9: The active count is cell_count clamped to the range 4 to 6. Cell positions at or above that count always pass the self-check, never shunt and never raise ov1_pull or ov2_pull.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | 1 = operating, 0 = standby |
| cell_count | input | 3 | Cells in use (clamped to 4 to 6), held static while operating |
| vsel | input | 3 | Balance level select, 2400 + 100·vsel mV |
| ofs_sel | input | 1 | Over-voltage offset select, 0 = narrow, 1 = wide |
| cell_mv | input | 72 | Cell codes in mV, cell i at bits [12i+11:12i] |
| drain_fb | input | 6 | Drain feedback per cell, 0 = drain reads low |
| tick_div | input | 16 | Prescaler limit, sample interval = tick_div+1 cycles |
| shunt_en | output | 6 | Shunt switch enable per cell |
| ov1_pull | output | 1 | Over-voltage level 1 pull-low enable |
| ov2_pull | output | 1 | Over-voltage level 2 pull-low enable |
| ok_pull | output | 1 | Self-check OK pull-low enable |

## Verification
A single cell can cross the balance level and both over-voltage levels in the same sample. Its three filters then switch at the same clock edge, so the shunt enable, both flags and the self-check output all change together. The bench provokes this by holding one cell exactly on, or exactly one code below, a chosen level while the other cells sit near the balance level. It does this for all sixteen combinations of level select and offset select. It then compares all four outputs in the cycle after the fourth sample against levels computed from the selects. A drain-feedback bit held high on the shunting cell in that same pattern shows that the self-check result follows the feedback even while the flags are rising.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   // width of threshold arithmetic; cell codes are widened to it
   localparam int THR_W = 16;
   localparam int NUM_LVL = 3;
   typedef enum logic [1:0] {
      LVL_BAL = 2'd0,
      LVL_OV1 = 2'd1,
      LVL_OV2 = 2'd2
   } cbs_lvl_e;
   typedef logic [THR_W-1:0] cbs_thr_t [NUM_LVL];
endpackage

// File: rtl/cbs_tick_gen.sv
module cbs_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   initial begin
      if (DIV_W < 1) $error("cbs_tick_gen: DIV_W must be positive");
   end

   assign tick = run && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (tick)    cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cbs_agree_filter.sv
module cbs_agree_filter #(
   parameter int LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic sample,
   input  logic raw,
   output logic state
);
   initial begin
      if (LEN < 1) $error("cbs_agree_filter: LEN must be at least 1");
   end

   generate
      if (LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      state <= 1'b0;
            else if (clear)  state <= 1'b0;
            else if (sample) state <= raw;
         end
      end else begin : g_counted
         localparam int RW = $clog2(LEN);
         localparam logic [RW-1:0] LAST = RW'(LEN - 1);
         logic [RW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state <= 1'b0;
               run_q <= '0;
            end else if (clear) begin
               state <= 1'b0;
               run_q <= '0;
            end else if (sample) begin
               if (raw == state) begin
                  run_q <= '0;
               end else if (run_q == LAST) begin
                  state <= raw;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cbs_thresholds.sv
module cbs_thresholds
   import cbs_pkg::*;
#(
   parameter int SEL_W   = 3,
   parameter int BASE_MV = 2400,
   parameter int STEP_MV = 100,
   parameter int OV1_LO  = 150,
   parameter int OV1_HI  = 250,
   parameter int OV2_LO  = 300,
   parameter int OV2_HI  = 500
) (
   input  logic [SEL_W-1:0] vsel,
   input  logic             ofs_sel,
   output cbs_thr_t         thr
);
   localparam int TOP_MV = BASE_MV + STEP_MV * ((1 << SEL_W) - 1)
                           + ((OV2_HI > OV2_LO) ? OV2_HI : OV2_LO);

   initial begin
      if (TOP_MV >= (1 << THR_W)) $error("cbs_thresholds: levels exceed THR_W");
      if (OV1_LO > OV2_LO || OV1_HI > OV2_HI) $error("cbs_thresholds: level 2 below level 1");
   end

   logic [THR_W-1:0] bal_mv;

   always_comb begin
      bal_mv       = THR_W'(BASE_MV) + THR_W'(STEP_MV) * THR_W'(vsel);
      thr[LVL_BAL] = bal_mv;
      thr[LVL_OV1] = bal_mv + (ofs_sel ? THR_W'(OV1_HI) : THR_W'(OV1_LO));
      thr[LVL_OV2] = bal_mv + (ofs_sel ? THR_W'(OV2_HI) : THR_W'(OV2_LO));
   end
endmodule

// File: rtl/cbs_cell_slice.sv
module cbs_cell_slice
   import cbs_pkg::*;
#(
   parameter int CODE_W   = 12,
   parameter int FILT_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              active,
   input  logic              sample,
   input  logic [CODE_W-1:0] code,
   input  cbs_thr_t          thr,
   output logic [NUM_LVL-1:0] det
);
   initial begin
      if (CODE_W > THR_W) $error("cbs_cell_slice: CODE_W wider than THR_W");
   end

   logic [THR_W-1:0]   code_w;
   logic [NUM_LVL-1:0] raw;
   logic [NUM_LVL-1:0] filt;

   assign code_w = THR_W'(code);

   generate
      for (genvar j = 0; j < NUM_LVL; j++) begin : g_lvl
         assign raw[j] = (code_w >= thr[j]);
         cbs_agree_filter #(.LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (clear || !active),
            .sample (sample),
            .raw    (raw[j]),
            .state  (filt[j])
         );
      end
   endgenerate

   assign det = active ? filt : '0;
endmodule

// File: rtl/cell_balance_ctrl.sv
module cell_balance_ctrl
   import cbs_pkg::*;
#(
   parameter int MAX_CELLS = 6,
   parameter int MIN_CELLS = 4,
   parameter int CODE_W    = 12,
   parameter int SEL_W     = 3,
   parameter int DIV_W     = 16,
   parameter int FILT_LEN  = 4,
   localparam int CNT_W    = $clog2(MAX_CELLS + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        enable,
   input  logic [CNT_W-1:0]            cell_count,
   input  logic [SEL_W-1:0]            vsel,
   input  logic                        ofs_sel,
   input  logic [MAX_CELLS*CODE_W-1:0] cell_mv,
   input  logic [MAX_CELLS-1:0]        drain_fb,
   input  logic [DIV_W-1:0]            tick_div,
   output logic [MAX_CELLS-1:0]        shunt_en,
   output logic                        ov1_pull,
   output logic                        ov2_pull,
   output logic                        ok_pull
);
   initial begin
      if (MIN_CELLS < 1 || MIN_CELLS > MAX_CELLS)
         $error("cell_balance_ctrl: MIN_CELLS out of range");
   end

   localparam logic [CNT_W-1:0] LO_CNT = CNT_W'(MIN_CELLS);
   localparam logic [CNT_W-1:0] HI_CNT = CNT_W'(MAX_CELLS);

   cbs_thr_t             thr;
   logic                 tick;
   logic [CNT_W-1:0]     ncell;
   logic [MAX_CELLS-1:0] active;
   logic [MAX_CELLS-1:0] bal_det;
   logic [MAX_CELLS-1:0] ov1_det;
   logic [MAX_CELLS-1:0] ov2_det;
   logic [MAX_CELLS-1:0] chk_pass;

   always_comb begin
      if (cell_count < LO_CNT)      ncell = LO_CNT;
      else if (cell_count > HI_CNT) ncell = HI_CNT;
      else                          ncell = cell_count;
   end

   cbs_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (enable),
      .div   (tick_div),
      .tick  (tick)
   );

   cbs_thresholds #(.SEL_W(SEL_W)) u_thr (
      .vsel    (vsel),
      .ofs_sel (ofs_sel),
      .thr     (thr)
   );

   generate
      for (genvar i = 0; i < MAX_CELLS; i++) begin : g_cell
         logic [NUM_LVL-1:0] det;
         assign active[i] = (CNT_W'(i) < ncell);
         cbs_cell_slice #(.CODE_W(CODE_W), .FILT_LEN(FILT_LEN)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (!enable),
            .active (active[i]),
            .sample (tick),
            .code   (cell_mv[i*CODE_W +: CODE_W]),
            .thr    (thr),
            .det    (det)
         );
         assign bal_det[i]  = det[LVL_BAL];
         assign ov1_det[i]  = det[LVL_OV1];
         assign ov2_det[i]  = det[LVL_OV2];
         assign shunt_en[i] = enable && bal_det[i];
         assign chk_pass[i] = !active[i] || (shunt_en[i] && !drain_fb[i]);
      end
   endgenerate

   assign ov1_pull = enable && (|ov1_det);
   assign ov2_pull = enable && (|ov2_det);
   assign ok_pull  = enable && (&chk_pass);
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
   parameter int MAX_CELLS = 6,
   parameter int CNT_W     = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 enable,
   input logic [CNT_W-1:0]     cell_count,
   input logic [MAX_CELLS-1:0] drain_fb,
   input logic [MAX_CELLS-1:0] shunt_en,
   input logic                 ov1_pull,
   input logic                 ov2_pull,
   input logic                 ok_pull,
   input logic                 tick
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_CELLS);

   // R6
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (shunt_en == '0 && !ov1_pull && !ov2_pull && !ok_pull));

   // R8
   ok_feedback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ok_pull |-> ((drain_fb & shunt_en) == '0 && enable));

   // R9
   top_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_count < FULL) |-> !shunt_en[MAX_CELLS-1]);

   // R4
   change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && $stable(cell_count) &&
       (!$stable(shunt_en) || !$stable(ov1_pull) || !$stable(ov2_pull)))
      |-> $past(tick));
endmodule

bind cell_balance_ctrl cbs_checker #(.MAX_CELLS(MAX_CELLS), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .cell_count (cell_count),
   .drain_fb   (drain_fb),
   .shunt_en   (shunt_en),
   .ov1_pull   (ov1_pull),
   .ov2_pull   (ov2_pull),
   .ok_pull    (ok_pull),
   .tick       (tick)
);

// File: tb/cell_balance_ctrl_tb.sv
`timescale 1ns/1ps
module cell_balance_ctrl_tb;
   localparam int NC = 6;
   localparam int CW = 12;
   localparam int DIVN = 3;
   localparam int PER = DIVN + 1;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic            enable;
   logic [2:0]      cell_count;
   logic [2:0]      vsel;
   logic            ofs_sel;
   logic [NC*CW-1:0] cell_mv;
   logic [NC-1:0]   drain_fb;
   logic [15:0]     tick_div;
   logic [NC-1:0]   shunt_en;
   logic            ov1_pull, ov2_pull, ok_pull;

   cell_balance_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cell_count(cell_count),
      .vsel(vsel), .ofs_sel(ofs_sel), .cell_mv(cell_mv), .drain_fb(drain_fb),
      .tick_div(tick_div), .shunt_en(shunt_en), .ov1_pull(ov1_pull),
      .ov2_pull(ov2_pull), .ok_pull(ok_pull)
   );

   int v [NC];
   logic [NC-1:0] fb;
   int vs, of, ncell;
   int checks = 0;
   int fails = 0;
   bit done = 0;

   function automatic int bal_of(int s);
      return 2400 + 100 * s;
   endfunction
   function automatic int ov1_of(int s, int o);
      return bal_of(s) + (o != 0 ? 250 : 150);
   endfunction
   function automatic int ov2_of(int s, int o);
      return bal_of(s) + (o != 0 ? 500 : 300);
   endfunction

   task automatic drive();
      for (int i = 0; i < NC; i++) cell_mv[i*CW +: CW] = CW'(v[i]);
      drain_fb   = fb;
      vsel       = 3'(vs);
      ofs_sel    = (of != 0);
      cell_count = 3'(ncell);
   endtask

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic check_all(string req);
      int eff;
      logic [NC-1:0] es;
      logic e1, e2, eok;
      eff = (ncell < 4) ? 4 : (ncell > 6 ? 6 : ncell);
      es = '0; e1 = 0; e2 = 0; eok = 1;
      for (int i = 0; i < NC; i++) begin
         if (i < eff) begin
            es[i] = (v[i] >= bal_of(vs));
            if (v[i] >= ov1_of(vs, of)) e1 = 1;
            if (v[i] >= ov2_of(vs, of)) e2 = 1;
            if (!(es[i] && !fb[i])) eok = 0;
         end
      end
      check({req, " shunt"}, 8'(shunt_en), 8'(es));
      check({req, " ov1"}, 8'(ov1_pull), 8'(e1));
      check({req, " ov2"}, 8'(ov2_pull), 8'(e2));
      check({req, " ok"}, 8'(ok_pull), 8'(eok));
   endtask

   // standby, apply inputs, enable; returns after edge 4*PER at a negedge
   task automatic settle();
      @(negedge clk); enable = 1'b0; drive();
      @(negedge clk); enable = 1'b1;
      repeat (4 * PER) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_all(int val);
      for (int i = 0; i < NC; i++) v[i] = val;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; enable = 1'b0; tick_div = 16'(DIVN);
      vs = 0; of = 0; ncell = 6; fb = '0; set_all(3000);
      drive();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R6 reset shunt", 8'(shunt_en), 8'h00);
      check("R6 reset flags", 8'({ov1_pull, ov2_pull, ok_pull}), 8'h0);
      rst_n = 1'b1;

      // R4: exact assertion latency with enable aligned to the interval
      set_all(2500);
      @(negedge clk); drive();
      @(negedge clk); enable = 1'b1;
      repeat (4 * PER - 1) @(posedge clk);
      @(negedge clk);
      check("R4 before fourth sample", 8'(shunt_en), 8'h00);
      @(posedge clk); @(negedge clk);
      check("R4 at fourth sample", 8'(shunt_en), 8'h3f);

      // R4: prescaler bypass, one sample per cycle
      @(negedge clk); enable = 1'b0; tick_div = 16'd0;
      @(negedge clk); enable = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R4 div0 early", 8'(shunt_en), 8'h00);
      @(posedge clk); @(negedge clk);
      check("R4 div0 fourth", 8'(shunt_en), 8'h3f);
      @(negedge clk); enable = 1'b0; tick_div = 16'(DIVN);

      // R6: standby releases at once and clears filter state
      settle();
      check("R6 operating", 8'(shunt_en), 8'h3f);
      enable = 1'b0; #0.5;
      check("R6 standby shunt", 8'(shunt_en), 8'h00);
      check("R6 standby ok", 8'(ok_pull), 8'h0);
      @(negedge clk); enable = 1'b1;
      repeat (4 * PER - 1) @(posedge clk);
      @(negedge clk);
      check("R6 cleared state restarts", 8'(shunt_en), 8'h00);
      @(posedge clk); @(negedge clk);
      check("R6 relearned", 8'(shunt_en), 8'h3f);

      // R5: release within three to four intervals
      v[0] = 2399; drive();
      repeat (2 * PER) @(posedge clk);
      @(negedge clk);
      check("R5 still held", 8'(shunt_en[0]), 8'h1);
      repeat (2 * PER + 1) @(posedge clk);
      @(negedge clk);
      check("R5 released", 8'(shunt_en), 8'h3e);

      // R5: short excursion ignored
      @(negedge clk); enable = 1'b0; set_all(2300); v[2] = 2500; drive();
      @(negedge clk); enable = 1'b1;
      repeat (2 * PER) @(posedge clk);
      @(negedge clk); v[2] = 2300; drive();
      repeat (6 * PER) @(posedge clk);
      @(negedge clk);
      check("R5 glitch ignored", 8'(shunt_en), 8'h00);

      // R1 R2 R3 R7 R8: full select sweep
      for (int s = 0; s < 8; s++) begin
         for (int o = 0; o < 2; o++) begin
            int k;
            vs = s; of = o; ncell = 6; k = (s + 3 * o) % NC;
            fb = '0; set_all(bal_of(s) - 1); v[k] = bal_of(s);
            settle(); check_all("R1 one at balance");
            set_all(bal_of(s)); v[k] = ov1_of(s, o) - 1;
            settle(); check_all("R2 below ov1");
            set_all(bal_of(s) + 5); v[k] = ov1_of(s, o);
            settle(); check_all("R2 R7 at ov1");
            set_all(bal_of(s)); v[k] = ov2_of(s, o) - 1;
            settle(); check_all("R3 below ov2");
            v[k] = ov2_of(s, o); fb[k] = 1'b1;
            settle(); check_all("R3 R8 at ov2 with feedback high");
         end
      end

      // R9: unused positions and count clamping
      vs = 0; of = 0; fb = 6'b110000;
      set_all(2400); v[4] = 4000; v[5] = 4000;
      ncell = 4; settle(); check_all("R9 four cells");
      check("R9 four cells ok", 8'(ok_pull), 8'h1);
      ncell = 5; fb = 6'b100000; settle(); check_all("R9 five cells");
      ncell = 2; fb = 6'b110000; settle(); check_all("R9 clamp low");
      ncell = 7; fb = 6'b000000; settle(); check_all("R9 clamp high");
      check("R9 clamp high ov2", 8'(ov2_pull), 8'h1);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule